// File: doc/BRIEF.md
# Logic and Shift Execution Unit

This unit computes one 32-bit result per clock from two operands. A group select input picks one of three families of operations. The first is a ten-entry bitwise family, which includes the implication and nonimplication functions. The second is a shift and rotate family that takes its count from operand c. The third is a family of shifts that take their count from a 16-bit immediate port. A 4-bit function code picks the operation within the chosen family.

The result is captured in a register at the clock edge after the inputs are presented. A registered illegal flag goes high in the same cycle. Any reserved code, or the unused group, raises the illegal flag and leaves the result register holding its previous value. Operand fetch and writeback belong to the surrounding pipeline.

Top module: `bitshift_unit`

## Requirements
- R1: With group 0, function codes 0, 1 and 2 give b AND c, b OR c and b XOR c. The value appears on `result` one clock after the inputs, and `illegal` is 0 in that same cycle.
- R2: With group 0, function codes 3, 4 and 5 give the bitwise inverses of AND, OR and XOR.
- R3: With group 0, function codes 6, 7, 8 and 9 give (~b & c), (b & ~c), (~b | c) and (b | ~c).
- R4: With group 0, function codes 10 to 15 are reserved. A reserved code sets `illegal` and leaves `result` unchanged.
- R5: The group encoding is 0 for logic, 1 for register-count shifts and 2 for immediate-count shifts. Group 3 is always illegal and leaves `result` unchanged.
- R6: With group 1, the count is the full 32-bit operand c. Code 0 is an arithmetic left shift, which fills with zeros. Code 1 is an arithmetic right shift, which copies b[31] into the vacated bits. Code 2 is a zero-fill left shift and code 3 is a zero-fill right shift.
- R7: With group 1, code 4 shifts left and code 5 shifts right, and both fill the vacated bits with ones.
- R8: With group 1, code 6 rotates left and code 7 rotates right, each by c mod 32.
- R9: A shift count of 32 or more saturates. The result is 32 copies of the fill bit: zero, one, or b[31] for an arithmetic right shift.
- R10: With group 2, the count is the zero-extended `imm_cnt`. Codes 3 to 8 give arithmetic left, arithmetic right, zero-fill left, zero-fill right, one-fill left and one-fill right. Every other code is illegal and leaves `result` unchanged.
- R11: With group 1, codes 8 to 15 are reserved. They set `illegal` and leave `result` unchanged.
- R12: While `rst_n` is low, `result` is 0 and `illegal` is 0. The `illegal` output is registered and clears on the first legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_sel | input | 2 | Family select: 0 logic, 1 register shift, 2 immediate shift |
| fn_code | input | 4 | Function code within the family |
| opnd_b | input | 32 | First operand; the value that is shifted |
| opnd_c | input | 32 | Second operand; the shift count in group 1 |
| imm_cnt | input | 16 | Shift count for group 2 |
| result | output | 32 | Registered result |
| illegal | output | 1 | Registered flag for a reserved code or group |

## Verification
The bench applies shift counts of exactly 31, 32 and very large values. A design that used only the low count bits for plain shifts would wrap around and show a shifted value here instead of the fill pattern. It applies arithmetic right shifts to negative operands, so sign filling is visible. It applies one-fill shifts to zero operands, where a design that filled with zeros would show up at once. Reserved codes are inserted right after distinct legal results, so a design that wrote the register on an illegal code would show a changed `result` in the next cycle. Rotates with counts above 31 confirm the mod-32 behaviour.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'd0,
    GRP_SHREG = 2'd1,
    GRP_SHIMM = 2'd2,
    GRP_NONE  = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ASL = 3'd0,
    SH_ASR = 3'd1,
    SH_ZL  = 3'd2,
    SH_ZR  = 3'd3,
    SH_OL  = 3'd4,
    SH_OR  = 3'd5,
    SH_RL  = 3'd6,
    SH_RR  = 3'd7
  } shop_e;

  typedef struct packed {
    logic  illegal;
    logic  use_logic;
    logic  use_imm;
    shop_e op;
  } dec_t;

  // Truth table per logic code, indexed by {b,c}: bit3=11, bit2=10, bit1=01, bit0=00
  function automatic logic [3:0] logic_lut(input logic [3:0] fn);
    case (fn)
      4'd0:    return 4'b1000; // and
      4'd1:    return 4'b1110; // or
      4'd2:    return 4'b0110; // xor
      4'd3:    return 4'b0111; // nand
      4'd4:    return 4'b0001; // nor
      4'd5:    return 4'b1001; // xnor
      4'd6:    return 4'b0010; // ~b & c
      4'd7:    return 4'b0100; // b & ~c
      4'd8:    return 4'b1011; // ~b | c
      4'd9:    return 4'b1101; // b | ~c
      default: return 4'b0000;
    endcase
  endfunction

  function automatic dec_t decode(input logic [1:0] grp, input logic [3:0] fn);
    dec_t d;
    d.illegal   = 1'b0;
    d.use_logic = 1'b0;
    d.use_imm   = 1'b0;
    d.op        = SH_ASL;
    case (grp_e'(grp))
      GRP_LOGIC: begin
        d.use_logic = 1'b1;
        d.illegal   = (fn > 4'd9);
      end
      GRP_SHREG: begin
        d.illegal = fn[3];
        d.op      = shop_e'(fn[2:0]);
      end
      GRP_SHIMM: begin
        d.use_imm = 1'b1;
        d.illegal = (fn < 4'd3) || (fn > 4'd8);
        d.op      = shop_e'(3'(fn - 4'd3));
      end
      default: d.illegal = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bsu_logic.sv
module bsu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       fn,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] y
);
  import bsu_pkg::*;

  logic [3:0] lut;
  assign lut = logic_lut(fn);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = lut[{b[i], c[i]}];
  end

endmodule

// File: rtl/bsu_shift.sv
module bsu_shift #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32
) (
  input  bsu_pkg::shop_e   op,
  input  logic [WIDTH-1:0] val,
  input  logic [CNT_W-1:0] cnt,
  output logic [WIDTH-1:0] y,
  output logic             sat,
  output logic             rot
);
  import bsu_pkg::*;

  localparam int SH_W = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONES = '1;

  function automatic logic [WIDTH-1:0] fill_shift(input logic [WIDTH-1:0] v,
                                                  input logic [SH_W-1:0] n,
                                                  input logic left,
                                                  input logic f);
    logic [WIDTH-1:0] fm;
    fm = {WIDTH{f}};
    if (left) return (v << n) | (fm & ~(ONES << n));
    else      return (v >> n) | (fm & ~(ONES >> n));
  endfunction

  function automatic logic [WIDTH-1:0] rotate(input logic [WIDTH-1:0] v,
                                              input logic [SH_W-1:0] n,
                                              input logic left);
    logic [2*WIDTH-1:0] d;
    if (left) begin
      d = {v, v} << n;
      return d[2*WIDTH-1:WIDTH];
    end else begin
      d = {v, v} >> n;
      return d[WIDTH-1:0];
    end
  endfunction

  logic [SH_W-1:0] n;
  logic            left;
  logic            fill;
  logic            big;

  assign n   = cnt[SH_W-1:0];
  assign big = (cnt >= CNT_W'(WIDTH));
  assign rot = (op == SH_RL) || (op == SH_RR);
  assign sat = big && !rot;

  always_comb begin
    left = 1'b0;
    fill = 1'b0;
    case (op)
      SH_ASL, SH_ZL: left = 1'b1;
      SH_OL: begin left = 1'b1; fill = 1'b1; end
      SH_ASR: fill = val[WIDTH-1];
      SH_OR:  fill = 1'b1;
      SH_RL:  left = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (rot)      y = rotate(val, n, left);
    else if (sat) y = {WIDTH{fill}};
    else          y = fill_shift(val, n, left, fill);
  end

endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       grp_sel,
  input  logic [3:0]       fn_code,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_c,
  input  logic [IMM_W-1:0] imm_cnt,
  output logic [WIDTH-1:0] result,
  output logic             illegal
);
  import bsu_pkg::*;

  localparam int CNT_W = (WIDTH > IMM_W) ? WIDTH : IMM_W;

  dec_t             dec;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] shift_y;
  logic [WIDTH-1:0] next_y;
  logic             sat_w;
  logic             rot_w;
  logic             rot_take_w;
  logic             zero_sat_w;
  logic [WIDTH-1:0] result_q;
  logic             illegal_q;

  assign dec = decode(grp_sel, fn_code);
  assign cnt = dec.use_imm ? CNT_W'(imm_cnt) : CNT_W'(opnd_c);

  bsu_logic #(.WIDTH(WIDTH)) u_logic (
    .fn (fn_code),
    .b  (opnd_b),
    .c  (opnd_c),
    .y  (logic_y)
  );

  bsu_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
    .op  (dec.op),
    .val (opnd_b),
    .cnt (cnt),
    .y   (shift_y),
    .sat (sat_w),
    .rot (rot_w)
  );

  assign next_y     = dec.use_logic ? logic_y : shift_y;
  assign rot_take_w = !dec.illegal && !dec.use_logic && rot_w;
  assign zero_sat_w = !dec.illegal && !dec.use_logic && sat_w &&
                      (dec.op == SH_ZL || dec.op == SH_ZR || dec.op == SH_ASL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q  <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= dec.illegal;
      if (!dec.illegal) result_q <= next_y;
    end
  end

  assign result  = result_q;
  assign illegal = illegal_q;

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> result_q == $past(result_q)); // R4

  AST_GRP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_sel == 2'b11 |=> illegal_q); // R5

  AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rot_take_w |=> $countones(result_q) == $countones($past(opnd_b))); // R8

  AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_sat_w |=> result_q == '0); // R9

  AST_LOGIC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_sel == 2'b00 && fn_code <= 4'd9) |=> !illegal_q); // R1

endmodule

// File: tb/bitshift_unit_bench.sv
module bitshift_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  grp_sel;
  logic [3:0]  fn_code;
  logic [31:0] opnd_b;
  logic [31:0] opnd_c;
  logic [15:0] imm_cnt;
  logic [31:0] result;
  logic        illegal;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic [31:0] exp_res;
  logic        exp_ill;

  always #5 clk = ~clk;

  bitshift_unit u_bitshift_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .grp_sel (grp_sel),
    .fn_code (fn_code),
    .opnd_b  (opnd_b),
    .opnd_c  (opnd_c),
    .imm_cnt (imm_cnt),
    .result  (result),
    .illegal (illegal)
  );

  // kind: 0 shift left, 1 shift right, 2 rotate left, 3 rotate right
  function automatic logic [31:0] ref_shift(input int kind, input logic [31:0] v,
                                            input longint n, input logic f);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (kind == 2)      r[i] = v[(i - int'(n % 32) + 32) % 32];
      else if (kind == 3) r[i] = v[(i + int'(n % 32)) % 32];
      else if (n >= 32)   r[i] = f;
      else if (kind == 0) r[i] = (i - n >= 0) ? v[i - int'(n)] : f;
      else                r[i] = (i + n < 32) ? v[i + int'(n)] : f;
    end
    return r;
  endfunction

  function automatic void ref_op(input logic [1:0] g, input logic [3:0] f,
                                 input logic [31:0] b, input logic [31:0] c,
                                 input logic [15:0] im,
                                 output bit ok, output logic [31:0] v);
    int     code;
    longint n;
    ok = 1;
    v  = '0;
    if (g == 0) begin
      case (f)
        0: v = b & c;
        1: v = b | c;
        2: v = b ^ c;
        3: v = ~b | ~c;
        4: v = ~b & ~c;
        5: v = (b & c) | (~b & ~c);
        6: v = ~b & c;
        7: v = b & ~c;
        8: v = ~b | c;
        9: v = b | ~c;
        default: ok = 0;
      endcase
    end else if (g == 1 || g == 2) begin
      if (g == 1) begin code = f; n = longint'(c); ok = (f < 8); end
      else begin code = int'(f) - 3; n = longint'(im); ok = (f >= 3 && f <= 8); end
      if (ok) begin
        case (code)
          0: v = ref_shift(0, b, n, 1'b0);
          1: v = ref_shift(1, b, n, b[31]);
          2: v = ref_shift(0, b, n, 1'b0);
          3: v = ref_shift(1, b, n, 1'b0);
          4: v = ref_shift(0, b, n, 1'b1);
          5: v = ref_shift(1, b, n, 1'b1);
          6: v = ref_shift(2, b, n, 1'b0);
          default: v = ref_shift(3, b, n, 1'b0);
        endcase
      end
    end else begin
      ok = 0;
    end
  endfunction

  function automatic string tag_of(input logic [1:0] g, input logic [3:0] f,
                                   input logic [31:0] c, input logic [15:0] im);
    if (g == 0) begin
      if (f <= 2) return "R1";
      if (f <= 5) return "R2";
      if (f <= 9) return "R3";
      return "R4";
    end
    if (g == 1) begin
      if (f >= 8) return "R11";
      if (f <= 5 && c >= 32) return "R9";
      if (f <= 3) return "R6";
      if (f <= 5) return "R7";
      return "R8";
    end
    if (g == 2) begin
      if (f >= 3 && f <= 8 && im >= 32) return "R9";
      return "R10";
    end
    return "R5";
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (result !== exp_res || illegal !== exp_ill) begin
      n_fail++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               tag, result, illegal, exp_res, exp_ill);
    end
  endtask

  task automatic step(input logic [1:0] g, input logic [3:0] f,
                      input logic [31:0] b, input logic [31:0] c,
                      input logic [15:0] im);
    bit          ok;
    logic [31:0] v;
    grp_sel = g; fn_code = f; opnd_b = b; opnd_c = c; imm_cnt = im;
    ref_op(g, f, b, c, im, ok, v);
    if (ok) exp_res = v;
    exp_ill = !ok;
    @(negedge clk);
    check(tag_of(g, f, c, im));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: result=%h illegal=%b expected completion", result, illegal);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; grp_sel = 2'd1; fn_code = 4'd4;
    opnd_b = 32'hFFFF_FFFF; opnd_c = 32'd3; imm_cnt = 16'd0;
    exp_res = '0; exp_ill = 1'b0;
    repeat (3) @(negedge clk);
    check("R12");                              // reset state
    rst_n = 1'b1;
    grp_sel = 2'd3;                            // illegal right after reset
    exp_ill = 1'b1;
    @(negedge clk);
    check("R5");

    // R1..R3 logic family on a mixed pattern
    for (int f = 0; f < 10; f++) step(2'd0, 4'(f), 32'hF0F0_A5A5, 32'hFF00_3C3C, 16'h0);
    // R4 reserved logic codes keep last result
    step(2'd0, 4'd1, 32'h1234_5678, 32'h0000_0001, 16'h0);
    for (int f = 10; f < 16; f++) step(2'd0, 4'(f), 32'hDEAD_BEEF, 32'h1, 16'h0);
    step(2'd0, 4'd3, 32'h0, 32'h0, 16'h0);   // R2 and R12: legal clears flag
    // R5 group 3 keeps result
    step(2'd3, 4'd0, 32'hAAAA_AAAA, 32'h5555_5555, 16'h0);

    // R6/R7 shifts, negative operand, assorted counts
    for (int f = 0; f < 6; f++) begin
      step(2'd1, 4'(f), 32'h8000_F00D, 32'd4, 16'h0);
      step(2'd1, 4'(f), 32'h8000_F00D, 32'd0, 16'h0);
      step(2'd1, 4'(f), 32'h8000_F00D, 32'd31, 16'h0);
      step(2'd1, 4'(f), 32'h0, 32'd7, 16'h0);     // one-fill visible on zero
      // R9 saturation
      step(2'd1, 4'(f), 32'h8000_F00D, 32'd32, 16'h0);
      step(2'd1, 4'(f), 32'h8000_F00D, 32'h8000_0001, 16'h0);
      step(2'd1, 4'(f), 32'h7000_F00D, 32'd100, 16'h0);
    end
    // R8 rotates, counts beyond 31 wrap
    for (int f = 6; f < 8; f++) begin
      step(2'd1, 4'(f), 32'h8000_0001, 32'd1, 16'h0);
      step(2'd1, 4'(f), 32'h1234_5678, 32'd36, 16'h0);
      step(2'd1, 4'(f), 32'h1234_5678, 32'd32, 16'h0);
      step(2'd1, 4'(f), 32'h1234_5678, 32'hFFFF_FFFF, 16'h0);
    end
    // R11 reserved shift codes
    step(2'd1, 4'd2, 32'h0000_00FF, 32'd8, 16'h0);
    for (int f = 8; f < 16; f++) step(2'd1, 4'(f), 32'hFFFF_0000, 32'd2, 16'h0);

    // R10 immediate forms; c carries a decoy count
    for (int f = 0; f < 16; f++) begin
      step(2'd2, 4'(f), 32'hC001_0F0F, 32'd1, 16'd5);
      step(2'd2, 4'(f), 32'h8001_0F0F, 32'd0, 16'd31);
      step(2'd2, 4'(f), 32'h8001_0F0F, 32'd3, 16'hFFFF);  // R9 saturation via immediate
    end

    // mixed pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] cc;
      cc = $urandom;
      if (k % 3 != 0) cc = cc % 40;
      step(2'($urandom), 4'($urandom), $urandom, cc, 16'($urandom % 48));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule